// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block moves bytes between a set of configuration items and host memory under the control of an in-memory descriptor. Software writes the 64-bit address of a descriptor into an address register. The write that completes the address starts the engine. The engine fetches the 16-byte descriptor over a byte-wide request/acknowledge memory bus and decodes its control word. It may switch to another configuration item, and it then reads, skips or writes bytes of that item. At the end it reports the outcome by writing a status word back into the descriptor. No status register holds the result.

The current item key and the byte offset inside that item are shared with a selector port. Through that port, firmware can also pick an item directly while the engine is idle. The item storage sits outside the block. The block presents the current key and offset and receives that item's length, its write permission and the byte at the offset. Reads of the address register return a fixed 8-byte identification signature. A feature word advertises that descriptor transfers are available.

Top module: `cfgdma_top`

## Requirements
- R1: A transfer starts on a 4-byte write at register offset 4 (this ORs the data into the low half of the address) or on an 8-byte write at offset 0 (this loads the whole address). A 4-byte write at offset 0 loads the high half and clears the low half. Every other write shape has no effect.
- R2: The address register returns to zero in the cycle a transfer starts, so a later low-half-only start uses a high half of zero.
- R3: A register read of `size` bytes (1, 2, 4 or 8) at offset `off` returns bytes off..off+size-1 of the signature "CFGDMA01" (byte 0 = 0x43), with the first byte most significant. A read that runs past byte 7, an illegal size, or no read strobe returns zero.
- R4: The descriptor is 16 bytes. The control word is at +0, the length at +4 and the host address at +8. All fields are big-endian.
- R5: Control bit 0x08 (select) loads the key from control bits 31:16 and clears the offset before any data moves. A key of N_ITEMS or more is an invalid item, with length zero and no write permission.
- R6: Control bit 0x02 (read) beats 0x10 (write), and write beats 0x04 (skip). With none of the three bits set, the length is treated as zero and the transfer succeeds.
- R7: A read copies item bytes from the current offset to consecutive host addresses. Each item byte advances the offset by one. Once the item is exhausted, the rest of the length is filled with zero bytes and the offset stays put.
- R8: A skip advances the offset by the smaller of the length and the bytes left in the item, and it touches no memory.
- R9: A write with nonzero length fails if the item is invalid or not writable, or if the length exceeds the bytes left in the item. A failed write changes no item byte and no offset. A valid write copies host bytes into the item and advances the offset.
- R10: A memory error during the descriptor fetch ends the fetch and applies no select. A memory error during data movement stops at that byte. Both cases report status 1.
- R11: On completion, the status (0 on success, 1 = error bit 0x01) is written as a 4-byte big-endian word to descriptor +0.
- R12: While busy, start writes and selector-port writes are ignored. When idle, a selector-port write sets the key and clears the offset.
- R13: The feature word reads 0x00000003 when descriptor transfers are enabled and 0x00000001 when they are not.
- R14: `busy` rises in the cycle after the starting write and stays high until the last status byte is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Address register write strobe |
| reg_rd | input | 1 | Address register read strobe |
| reg_off | input | 3 | Byte offset of the register access |
| reg_size | input | 4 | Access size in bytes |
| reg_wdata | input | 64 | Write value, right-aligned |
| reg_rdata | output | 64 | Signature slice, right-aligned |
| feature_bits | output | 32 | Feature identification word |
| sel_wr | input | 1 | Selector port write strobe |
| sel_key | input | 16 | Selector port key |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a byte write |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 8 | Memory read byte, valid with acknowledge |
| mem_err | input | 1 | Memory error, valid with acknowledge |
| item_key | output | 16 | Current item key |
| item_off | output | 32 | Current byte offset in the item |
| item_len | input | 32 | Length of the current item |
| item_writable | input | 1 | Current item accepts writes |
| item_rdata | input | 8 | Item byte at the current offset |
| item_we | output | 1 | Item byte write strobe |
| item_wdata | output | 8 | Item write byte |

## Verification
Signature slices and the feature word are combinational, so they are due in the same cycle as the read inputs. They are compared with a bench model two nanoseconds after every falling edge. The selector port and start writes take effect at the next rising edge, so key, offset and `busy` are sampled at the falling edge that follows. The cycle count of a transfer depends on the memory acknowledge latency, so memory images, item contents, key and offset are compared against the behavioural model only after `busy` falls, that is, after the final status byte is acknowledged.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;

    localparam int ADDR_W = 64;
    localparam int LEN_W  = 32;
    localparam int KEY_W  = 16;
    localparam int DESC_BYTES = 16;
    localparam int STAT_BYTES = 4;

    // control word bit positions
    localparam int CB_ERR  = 0;
    localparam int CB_RD   = 1;
    localparam int CB_SKIP = 2;
    localparam int CB_SEL  = 3;
    localparam int CB_WR   = 4;

    typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE, OP_SKIP} op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DECODE, ST_CHECK, ST_MOVE, ST_WBACK
    } state_e;

    typedef struct packed {
        logic [LEN_W-1:0]  ctrl;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] haddr;
    } desc_t;

    function automatic op_e decode_op(input logic [LEN_W-1:0] c);
        if (c[CB_RD])        return OP_READ;
        else if (c[CB_WR])   return OP_WRITE;
        else if (c[CB_SKIP]) return OP_SKIP;
        return OP_NONE;
    endfunction

    function automatic logic [63:0] sig_slice(input logic [63:0] sig,
                                              input logic [2:0] off,
                                              input logic [3:0] size);
        logic [63:0] v;
        int sh;
        int o;
        int s;
        v = '0;
        o = int'(off);
        s = int'(size);
        if ((s == 1 || s == 2 || s == 4 || s == 8) && (o + s <= 8)) begin
            sh = (8 - o - s) * 8;
            v  = sig >> sh;
            if (s != 8) v = v & ((64'd1 << (s * 8)) - 64'd1);
        end
        return v;
    endfunction

endpackage

// File: rtl/cfgdma_regs.sv
module cfgdma_regs
    import cfgdma_pkg::*;
#(
    parameter logic [63:0] SIG    = 64'h4346_4744_4D41_3031,
    parameter bit          DMA_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_off,
    input  logic [3:0]        reg_size,
    input  logic [63:0]       reg_wdata,
    input  logic              busy,
    output logic [63:0]       reg_rdata,
    output logic [31:0]       feature_bits,
    output logic              start,
    output logic [ADDR_W-1:0] start_addr
);
    logic [ADDR_W-1:0] addr_q;
    logic hi_wr, lo_wr, full_wr;

    assign hi_wr   = reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd0;
    assign lo_wr   = reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd4;
    assign full_wr = reg_wr && !busy && reg_size == 4'd8 && reg_off == 3'd0;

    assign start      = lo_wr || full_wr;
    assign start_addr = full_wr ? reg_wdata : (addr_q | {32'b0, reg_wdata[31:0]});

    always_ff @(posedge clk) begin
        if (rst)        addr_q <= '0;
        else if (start) addr_q <= '0;
        else if (hi_wr) addr_q <= {reg_wdata[31:0], 32'b0};
    end

    assign reg_rdata    = reg_rd ? sig_slice(SIG, reg_off, reg_size) : 64'd0;
    assign feature_bits = DMA_EN ? 32'h0000_0003 : 32'h0000_0001;

    assert_addr_cleared_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> addr_q == '0);

endmodule

// File: rtl/cfgdma_sel.sv
module cfgdma_sel
    import cfgdma_pkg::*;
#(
    parameter int N_ITEMS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy,
    input  logic             port_sel,
    input  logic [KEY_W-1:0] port_key,
    input  logic             eng_sel,
    input  logic [KEY_W-1:0] eng_key,
    input  logic             eng_adv,
    input  logic [LEN_W-1:0] eng_adv_amt,
    output logic [KEY_W-1:0] cur_key,
    output logic [LEN_W-1:0] cur_off,
    output logic             key_ok
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_key <= '0;
            cur_off <= '0;
        end else if (eng_sel) begin
            cur_key <= eng_key;
            cur_off <= '0;
        end else if (port_sel && !busy) begin
            cur_key <= port_key;
            cur_off <= '0;
        end else if (eng_adv) begin
            cur_off <= cur_off + eng_adv_amt;
        end
    end

    assign key_ok = 32'(cur_key) < N_ITEMS;

    assert_sel_clears_off_R5: assert property (@(posedge clk) disable iff (rst)
        eng_sel |=> cur_off == '0);

    assert_port_ignored_busy_R12: assert property (@(posedge clk) disable iff (rst)
        busy && port_sel && !eng_sel |=> $stable(cur_key));

endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ack,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_err,
    output logic              eng_sel,
    output logic [KEY_W-1:0]  eng_key,
    output logic              eng_adv,
    output logic [LEN_W-1:0]  eng_adv_amt,
    input  logic [LEN_W-1:0]  cur_off,
    input  logic              key_ok,
    input  logic [LEN_W-1:0]  item_len,
    input  logic              item_writable,
    input  logic [7:0]        item_rdata,
    output logic              item_we,
    output logic [7:0]        item_wdata
);
    state_e            state;
    op_e               op;
    desc_t             dbuf;
    logic [ADDR_W-1:0] desc_addr;
    logic [ADDR_W-1:0] haddr;
    logic [LEN_W-1:0]  rem;
    logic [3:0]        cnt;
    logic              status;

    logic              in_range;
    logic [LEN_W-1:0]  avail;
    logic              moving;

    assign in_range = key_ok && (cur_off < item_len);
    assign avail    = in_range ? (item_len - cur_off) : '0;
    assign busy     = state != ST_IDLE;
    assign moving   = state == ST_MOVE;

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + ADDR_W'(cnt);
            end
            ST_MOVE: begin
                mem_req   = 1'b1;
                mem_we    = op == OP_READ;
                mem_addr  = haddr;
                mem_wdata = (op == OP_READ && in_range) ? item_rdata : 8'd0;
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + ADDR_W'(cnt);
                mem_wdata = (cnt == 4'd3) ? {7'd0, status} : 8'd0;
            end
            default: ;
        endcase
    end

    assign eng_sel = state == ST_DECODE && dbuf.ctrl[CB_SEL];
    assign eng_key = dbuf.ctrl[31:16];

    always_comb begin
        eng_adv     = 1'b0;
        eng_adv_amt = LEN_W'(1);
        if (moving && mem_ack && !mem_err && in_range && op != OP_SKIP) begin
            eng_adv = 1'b1;
        end else if (state == ST_CHECK && op == OP_SKIP && rem != '0) begin
            eng_adv     = 1'b1;
            eng_adv_amt = (rem < avail) ? rem : avail;
        end
    end

    assign item_we    = moving && op == OP_WRITE && mem_ack && !mem_err;
    assign item_wdata = mem_rdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            op        <= OP_NONE;
            dbuf      <= '0;
            desc_addr <= '0;
            haddr     <= '0;
            rem       <= '0;
            cnt       <= '0;
            status    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    desc_addr <= start_addr;
                    cnt       <= '0;
                    status    <= 1'b0;
                    state     <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_err) begin
                        status <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_WBACK;
                    end else begin
                        dbuf <= desc_t'({dbuf[8*DESC_BYTES-9:0], mem_rdata});
                        cnt  <= cnt + 4'd1;
                        if (cnt == 4'(DESC_BYTES - 1)) state <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    op     <= decode_op(dbuf.ctrl);
                    rem    <= (decode_op(dbuf.ctrl) == OP_NONE) ? '0 : dbuf.len;
                    haddr  <= dbuf.haddr;
                    status <= 1'b0;
                    state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    cnt <= '0;
                    if (rem == '0 || op == OP_SKIP || op == OP_NONE) begin
                        state <= ST_WBACK;
                    end else if (op == OP_WRITE &&
                                 (!(item_writable && key_ok) || rem > avail)) begin
                        status <= 1'b1;
                        state  <= ST_WBACK;
                    end else begin
                        state <= ST_MOVE;
                    end
                end
                ST_MOVE: if (mem_ack) begin
                    if (mem_err) begin
                        status <= 1'b1;
                        state  <= ST_WBACK;
                    end else begin
                        haddr <= haddr + ADDR_W'(1);
                        rem   <= rem - LEN_W'(1);
                        if (rem == LEN_W'(1)) state <= ST_WBACK;
                    end
                end
                ST_WBACK: if (mem_ack) begin
                    cnt <= cnt + 4'd1;
                    if (cnt == 4'(STAT_BYTES - 1)) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    assert_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
        moving && op == OP_READ && !in_range |-> mem_wdata == 8'd0);

    assert_wback_writes_R11: assert property (@(posedge clk) disable iff (rst)
        state == ST_WBACK |-> mem_req && mem_we);

    assert_item_write_bounded_R9: assert property (@(posedge clk) disable iff (rst)
        item_we |-> in_range && item_writable);

    assert_start_ignored_busy_R12: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(desc_addr));

endmodule

// File: rtl/cfgdma_top.sv
module cfgdma_top
    import cfgdma_pkg::*;
#(
    parameter int          N_ITEMS = 4,
    parameter logic [63:0] SIG     = 64'h4346_4744_4D41_3031,
    parameter bit          DMA_EN  = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_off,
    input  logic [3:0]  reg_size,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic [31:0] feature_bits,
    input  logic        sel_wr,
    input  logic [15:0] sel_key,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_err,
    output logic [15:0] item_key,
    output logic [31:0] item_off,
    input  logic [31:0] item_len,
    input  logic        item_writable,
    input  logic [7:0]  item_rdata,
    output logic        item_we,
    output logic [7:0]  item_wdata
);
    logic              start;
    logic [ADDR_W-1:0] start_addr;
    logic              eng_sel;
    logic [KEY_W-1:0]  eng_key;
    logic              eng_adv;
    logic [LEN_W-1:0]  eng_adv_amt;
    logic              key_ok;

    cfgdma_regs #(.SIG(SIG), .DMA_EN(DMA_EN)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .busy(busy), .reg_rdata(reg_rdata), .feature_bits(feature_bits),
        .start(start), .start_addr(start_addr)
    );

    cfgdma_sel #(.N_ITEMS(N_ITEMS)) u_sel (
        .clk(clk), .rst(rst), .busy(busy),
        .port_sel(sel_wr), .port_key(sel_key),
        .eng_sel(eng_sel), .eng_key(eng_key),
        .eng_adv(eng_adv), .eng_adv_amt(eng_adv_amt),
        .cur_key(item_key), .cur_off(item_off), .key_ok(key_ok)
    );

    cfgdma_engine u_eng (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .eng_sel(eng_sel), .eng_key(eng_key),
        .eng_adv(eng_adv), .eng_adv_amt(eng_adv_amt), .cur_off(item_off),
        .key_ok(key_ok), .item_len(item_len), .item_writable(item_writable),
        .item_rdata(item_rdata), .item_we(item_we), .item_wdata(item_wdata)
    );

    assert_busy_rises_R14: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> busy);

endmodule

// File: tb/cfgdma_top_tb_top.sv
module cfgdma_top_tb_top;
    localparam int MEMSZ = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_off = '0;
    logic [3:0]  reg_size = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [31:0] feature_bits;
    logic        sel_wr = 1'b0;
    logic [15:0] sel_key = '0;
    logic        busy, mem_req, mem_we, mem_ack, mem_err;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [15:0] item_key;
    logic [31:0] item_off, item_len;
    logic        item_writable, item_we;
    logic [7:0]  item_rdata, item_wdata;

    logic [7:0]  mem [MEMSZ];
    logic [7:0]  idata [4][16];
    logic        bd_we = 1'b0;
    logic [11:0] bd_addr = '0;
    logic [7:0]  bd_data = '0;

    logic [7:0]  exp_mem [MEMSZ];
    logic [7:0]  exp_idata [4][16];
    int          exp_key, exp_off;
    int          vectors = 0, fails = 0;

    always #5 clk = ~clk;

    cfgdma_top dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
        .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .feature_bits(feature_bits), .sel_wr(sel_wr), .sel_key(sel_key), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .item_key(item_key), .item_off(item_off), .item_len(item_len),
        .item_writable(item_writable), .item_rdata(item_rdata),
        .item_we(item_we), .item_wdata(item_wdata)
    );

    function automatic int ilen(int k);
        case (k)
            0: return 6;
            1: return 12;
            2: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic bit iwr(int k);
        return k == 1 || k == 2 || k == 3;
    endfunction

    assign item_len      = (item_key < 16'd4) ? 32'(ilen(int'(item_key))) : 32'd0;
    assign item_writable = (item_key < 16'd4) && iwr(int'(item_key));
    assign item_rdata    = (item_key < 16'd4 && item_off < 32'd16) ?
                           idata[item_key[1:0]][item_off[3:0]] : 8'd0;
    assign mem_err       = mem_ack && (mem_addr >= 64'(MEMSZ));
    assign mem_rdata     = (mem_addr < 64'(MEMSZ)) ? mem[mem_addr[11:0]] : 8'd0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEMSZ; i++) mem[i] <= 8'(i * 3);
            for (int k = 0; k < 4; k++)
                for (int j = 0; j < 16; j++) idata[k][j] <= 8'(k * 16 + j + 64);
            mem_ack <= 1'b0;
        end else begin
            if (bd_we) mem[bd_addr] <= bd_data;
            if (mem_ack && mem_we && mem_addr < 64'(MEMSZ)) mem[mem_addr[11:0]] <= mem_wdata;
            if (item_we && item_key < 16'd4 && item_off < 32'd16)
                idata[item_key[1:0]][item_off[3:0]] <= item_wdata;
            mem_ack <= mem_req && !mem_ack;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // R3 / R13: signature and feature word model, compared on every clock
    function automatic logic [63:0] sig_model(bit rd, int o, int s);
        logic [7:0] sb [8];
        logic [63:0] v;
        sb = '{8'h43, 8'h46, 8'h47, 8'h44, 8'h4D, 8'h41, 8'h30, 8'h31};
        v = '0;
        if (!rd || !(s == 1 || s == 2 || s == 4 || s == 8) || o + s > 8) return v;
        for (int i = 0; i < s; i++) v = (v << 8) | 64'(sb[o + i]);
        return v;
    endfunction

    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk(reg_rdata == sig_model(reg_rd, int'(reg_off), int'(reg_size)), "R3 signature",
                reg_rdata, sig_model(reg_rd, int'(reg_off), int'(reg_size)));
            chk(feature_bits == 32'h3, "R13 feature", 64'(feature_bits), 64'h3);
        end
    end

    task automatic poke(input int a, input logic [7:0] d);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = 12'(a); bd_data = d;
        @(negedge clk);
        bd_we = 1'b0;
        exp_mem[a] = d;
    endtask

    task automatic put_desc(input int da, input logic [31:0] c, input logic [31:0] l,
                            input logic [63:0] h);
        logic [127:0] w;
        w = {c, l, h};
        for (int i = 0; i < 16; i++)
            if (da + i < MEMSZ) poke(da + i, w[127 - 8*i -: 8]);
    endtask

    task automatic wr_reg(input logic [2:0] o, input logic [3:0] s, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_off = o; reg_size = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] o, input logic [3:0] s);
        @(negedge clk);
        reg_rd = 1'b1; reg_off = o; reg_size = s;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic run_model(input logic [63:0] da);
        logic [7:0]  b [16];
        bit          ferr;
        logic [31:0] c, l;
        logic [63:0] h, a;
        int          st, op, il, av;
        ferr = 0; st = 0;
        for (int i = 0; i < 16; i++) begin
            if (da + 64'(i) >= 64'(MEMSZ)) ferr = 1;
            else b[i] = exp_mem[32'(da) + i];
        end
        if (ferr) st = 1;
        else begin
            c = {b[0], b[1], b[2], b[3]};
            l = {b[4], b[5], b[6], b[7]};
            h = {b[8], b[9], b[10], b[11], b[12], b[13], b[14], b[15]};
            if (c[3]) begin exp_key = int'(c[31:16]); exp_off = 0; end
            op = c[1] ? 1 : c[4] ? 2 : c[2] ? 3 : 0;
            if (op == 0) l = 0;
            il = (exp_key < 4) ? ilen(exp_key) : 0;
            av = (exp_off < il) ? il - exp_off : 0;
            if (l != 0) begin
                if (op == 1) begin
                    for (int n = 0; n < int'(l); n++) begin
                        a = h + 64'(n);
                        if (a >= 64'(MEMSZ)) begin st = 1; break; end
                        if (exp_off < il) begin
                            exp_mem[32'(a)] = exp_idata[exp_key][exp_off];
                            exp_off++;
                        end else exp_mem[32'(a)] = 8'd0;
                    end
                end else if (op == 2) begin
                    if (!(exp_key < 4 && iwr(exp_key)) || int'(l) > av) st = 1;
                    else for (int n = 0; n < int'(l); n++) begin
                        a = h + 64'(n);
                        if (a >= 64'(MEMSZ)) begin st = 1; break; end
                        exp_idata[exp_key][exp_off] = exp_mem[32'(a)];
                        exp_off++;
                    end
                end else if (op == 3) begin
                    exp_off += (int'(l) < av) ? int'(l) : av;
                end
            end
        end
        for (int i = 0; i < 4; i++)
            if (da + 64'(i) < 64'(MEMSZ)) exp_mem[32'(da) + i] = (i == 3) ? 8'(st) : 8'd0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        repeat (2) @(negedge clk);
    endtask

    task automatic compare_all(input string req);
        int bad;
        bad = -1;
        for (int i = MEMSZ - 1; i >= 0; i--) if (mem[i] !== exp_mem[i]) bad = i;
        chk(bad < 0, {req, " memory image"}, (bad < 0) ? 0 : 64'(mem[bad]),
            (bad < 0) ? 0 : 64'(exp_mem[bad]));
        bad = -1;
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 16; j++) if (idata[k][j] !== exp_idata[k][j]) bad = k * 16 + j;
        chk(bad < 0, {req, " item bytes"}, 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        chk(int'(item_key) == exp_key, {req, " key"}, 64'(item_key), 64'(exp_key));
        chk(int'(item_off) == exp_off, {req, " offset"}, 64'(item_off), 64'(exp_off));
    endtask

    task automatic go_full(input logic [63:0] da, input string req);
        wr_reg(3'd0, 4'd8, da);
        chk(busy == 1'b1, {req, " R14 busy after start"}, 64'(busy), 64'd1);
        run_model(da);
        wait_idle();
        compare_all(req);
    endtask

    task automatic go_halves(input logic [63:0] da, input string req);
        wr_reg(3'd0, 4'd4, {32'd0, da[63:32]});
        wr_reg(3'd4, 4'd4, {32'd0, da[31:0]});
        run_model(da);
        wait_idle();
        compare_all(req);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) exp_mem[i] = 8'(i * 3);
        for (int k = 0; k < 4; k++)
            for (int j = 0; j < 16; j++) exp_idata[k][j] = 8'(k * 16 + j + 64);
        exp_key = 0; exp_off = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(busy == 1'b0, "R14 reset busy", 64'(busy), 0);
        chk(mem_req == 1'b0, "R14 reset mem_req", 64'(mem_req), 0);
        chk(item_key == 16'd0 && item_off == 32'd0, "R12 reset key/offset", 64'(item_key), 0);
        chk(feature_bits == 32'h3, "R13 feature word", 64'(feature_bits), 64'h3);

        // R3: explicit signature slices
        rd_reg(3'd0, 4'd8); rd_reg(3'd4, 4'd2); rd_reg(3'd7, 4'd1);
        rd_reg(3'd6, 4'd4); rd_reg(3'd1, 4'd3);

        // R12: selector port while idle
        @(negedge clk); sel_wr = 1'b1; sel_key = 16'd1;
        @(negedge clk); sel_wr = 1'b0;
        exp_key = 1; exp_off = 0;
        chk(item_key == 16'd1 && item_off == 0, "R12 port select", 64'(item_key), 1);

        // R4 R5 R7 R11: read with select, zero fill past item end
        put_desc(32'h100, 32'h0000_000A, 32'd10, 64'h200);
        go_halves(64'h100, "R7 read+fill");
        // R8: skip then continued read without select
        put_desc(32'h120, 32'h0001_000C, 32'd5, 64'h0);
        go_full(64'h120, "R8 skip");
        put_desc(32'h140, 32'h0000_0002, 32'd4, 64'h300);
        go_full(64'h140, "R8 read after skip");
        // R6: priority and no-op
        put_desc(32'h160, 32'h0002_001E, 32'd3, 64'h340);
        go_full(64'h160, "R6 read wins");
        put_desc(32'h180, 32'h0001_0008, 32'd7, 64'h360);
        go_full(64'h180, "R6 no op zero length");
        // R9: writes
        put_desc(32'h1A0, 32'h0001_0018, 32'd4, 64'h400);
        go_full(64'h1A0, "R9 write ok");
        put_desc(32'h1C0, 32'h0000_0018, 32'd2, 64'h400);
        go_full(64'h1C0, "R9 read-only item");
        put_desc(32'h1E0, 32'h0002_0018, 32'd9, 64'h400);
        go_full(64'h1E0, "R9 past end");
        put_desc(32'h200, 32'h0007_0018, 32'd1, 64'h400);
        go_full(64'h200, "R9 invalid key R5");
        put_desc(32'h220, 32'h0003_0018, 32'd1, 64'h400);
        go_full(64'h220, "R9 empty item");
        put_desc(32'h240, 32'h0002_0018, 32'd3, 64'h410);
        go_full(64'h240, "R9 write item2");

        // R1: rejected write shapes
        put_desc(32'h0, 32'h0001_000A, 32'd2, 64'h700);
        wr_reg(3'd4, 4'd8, 64'h0);
        chk(busy == 1'b0, "R1 reject off4 size8", 64'(busy), 0);
        wr_reg(3'd0, 4'd2, 64'h0);
        chk(busy == 1'b0, "R1 reject size2", 64'(busy), 0);
        wr_reg(3'd2, 4'd4, 64'h0);
        chk(busy == 1'b0, "R1 reject off2", 64'(busy), 0);
        wr_reg(3'd4, 4'd1, 64'h0);
        chk(busy == 1'b0, "R1 reject size1", 64'(busy), 0);
        repeat (4) @(negedge clk);
        compare_all("R1 rejected shapes");

        // R2: high half cleared on start
        put_desc(32'h2C0, 32'h0002_000A, 32'd3, 64'h720);
        wr_reg(3'd0, 4'd4, 64'h1);
        wr_reg(3'd4, 4'd4, 64'h2C0);
        run_model(64'h1_0000_02C0);
        wait_idle();
        compare_all("R2 high half errors");
        wr_reg(3'd4, 4'd4, 64'h2C0);
        run_model(64'h2C0);
        wait_idle();
        compare_all("R2 low half only");

        // R10: fetch error part way and data error part way
        put_desc(MEMSZ - 8, 32'h0000_000A, 32'd2, 64'h0);
        go_full(64'(MEMSZ - 8), "R10 fetch error");
        put_desc(32'h300, 32'h0001_000A, 32'd4, 64'(MEMSZ - 2));
        go_full(64'h300, "R10 data error");

        // R12 R14: start and selector writes ignored while busy
        put_desc(32'h320, 32'h0002_000A, 32'd8, 64'h500);
        put_desc(32'h340, 32'h0000_000A, 32'd4, 64'h540);
        wr_reg(3'd0, 4'd8, 64'h320);
        run_model(64'h320);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R14 busy during transfer", 64'(busy), 1);
        wr_reg(3'd0, 4'd8, 64'h340);
        @(negedge clk); sel_wr = 1'b1; sel_key = 16'd3;
        @(negedge clk); sel_wr = 1'b0;
        chk(busy == 1'b1, "R12 still busy", 64'(busy), 1);
        wait_idle();
        compare_all("R12 ignored while busy");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule